// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer Channel

This block is a single timer channel that counts down from a programmable reload value. When the count is at zero, the next tick loads the reload value again, so the channel runs as a free-running periodic timer. Ticks come either from every bus clock or from a slow external tick. The external tick is synchronised into the clock domain and edge-detected, so each rising edge of it gives exactly one count step.

Two match values and the zero point can raise events. A match value takes part only while it is below the reload value; a larger value is treated as zero. An event inverts a level-type interrupt output and produces a one-cycle event pulse, which a status register outside the block collects. Software loads the count, reload and match values through plain write strobes that share one data bus. The channel shows the live count while it is enabled and the reload value while it is disabled.

Top module: `dmt_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `count_o`, `irq_level` and `event_pulse` are 0. Reset clears the reload value, both match values, the interrupt level and the running state.
- R2: While the channel is not running, `count_o` shows the reload register. A reload write made while disabled appears on `count_o` one cycle after the write.
- R3: At the first clock edge where `en` is seen high after being low, the count is loaded from the reload value. `count_o` shows that value after the edge.
- R4: While running, each accepted tick lowers a nonzero count by one. A tick at count zero loads the reload value and raises no event.
- R5: With `tick_src` = 0 every clock is a tick. With `tick_src` = 1 the count drops by exactly one for each rising edge of `ext_tick`, after a fixed synchroniser delay. A steady `ext_tick` level and the `ext_tick` input in mode 0 have no effect.
- R6: A match value takes effect only when it is below the current reload value. Otherwise it is treated as zero, and it raises no event at its own value.
- R7: A decrement that brings the count to a nonzero effective match value raises an event.
- R8: A decrement that brings the count to zero raises an event when `ovf_irq_en` is 1 or when either effective match value is zero.
- R9: Each event drives `event_pulse` high for the one cycle after the decrement and inverts `irq_level` in that same cycle. Without an event, `irq_level` holds.
- R10: A count write while running loads `wr_data` as the count and takes priority over the tick in that cycle. A count write while disabled has no effect.
- R11: Writing a nonzero reload while running, with the old reload at zero, restarts counting from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Channel enable |
| tick_src | input | 1 | 0: tick every clock, 1: tick on external rising edge |
| ovf_irq_en | input | 1 | Raise an event when the count reaches zero |
| ext_tick | input | 1 | Slow external tick, asynchronous |
| wr_count | input | 1 | Write strobe for the current count |
| wr_reload | input | 1 | Write strobe for the reload value |
| wr_match0 | input | 1 | Write strobe for match value 0 |
| wr_match1 | input | 1 | Write strobe for match value 1 |
| wr_data | input | CNT_W | Shared write data |
| count_o | output | CNT_W | Live count when running, reload value when not |
| irq_level | output | 1 | Interrupt level, inverted by each event |
| event_pulse | output | 1 | One-cycle pulse for each event |

## Verification
A wrong count shows at `count_o` in the cycle after the faulty edge, because the port reads the count register directly while the channel runs. A wrong match or reload register shows up one decrement late: the event pulse appears, or fails to appear, in the cycle after the count passes the match point, and the interrupt level then stays at the wrong parity until the next event. The bench therefore compares count, pulse and level after every clock edge against a model written from the requirements. Any such fault is reported in the same cycle it reaches the ports.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
   typedef enum logic {
      TICK_BUS = 1'b0,
      TICK_EXT = 1'b1
   } tick_src_e;

   localparam int unsigned NUM_MATCH = 2;
endpackage

// File: rtl/dmt_tick_gen.sv
module dmt_tick_gen #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_sel,
   input  logic ext_tick,
   output logic tick_o
);
   import dmt_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("dmt_tick_gen: SYNC_STAGES must be at least 2");
   end

   localparam int unsigned TOP = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   ext_edge;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], ext_tick};
         prev_q <= sync_q[TOP];
      end
   end

   assign ext_edge = sync_q[TOP] & ~prev_q;
   assign tick_o   = (tick_src_e'(src_sel) == TICK_EXT) ? ext_edge : 1'b1;

   // R5
   ext_edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_edge |=> !ext_edge);
endmodule

// File: rtl/dmt_match_unit.sv
module dmt_match_unit #(
   parameter int unsigned CNT_W = 32
) (
   input  logic [CNT_W-1:0]                      reload_i,
   input  logic [dmt_pkg::NUM_MATCH-1:0][CNT_W-1:0] match_i,
   input  logic [CNT_W-1:0]                      cnt_i,
   input  logic                                  ovf_en_i,
   output logic                                  step_evt_o
);
   import dmt_pkg::*;

   logic [CNT_W-1:0]     next_cnt;
   logic [NUM_MATCH-1:0] hit;
   logic [NUM_MATCH-1:0] eff_zero;

   assign next_cnt = cnt_i - 1'b1;

   for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
      logic [CNT_W-1:0] eff;
      assign eff         = (match_i[i] < reload_i) ? match_i[i] : '0;
      assign eff_zero[i] = (eff == '0);
      assign hit[i]      = (next_cnt != '0) && (next_cnt == eff);
   end

   always_comb begin
      if (next_cnt == '0) begin
         step_evt_o = ovf_en_i | (|eff_zero);
      end else begin
         step_evt_o = |hit;
      end
   end
endmodule

// File: rtl/dmt_count_core.sv
module dmt_count_core #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             wr_count,
   input  logic             wr_reload,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [CNT_W-1:0] reload_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             run_q,
   output logic             dec_o
);
   logic restart;

   assign restart = wr_reload && (reload_q == '0) && (wr_data != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         run_q <= en;
         if (en) begin
            if (!run_q) begin
               cnt_q <= reload_q;
            end else if (wr_count || restart) begin
               cnt_q <= wr_data;
            end else if (tick) begin
               cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
            end
         end
      end
   end

   assign dec_o = en && run_q && !wr_count && !restart && tick && (cnt_q != '0);

   // R3
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !run_q) |=> (cnt_q == $past(reload_q)));
   // R4
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && en && tick && !wr_count && !restart && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - 1'b1));
   // R4
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && en && tick && !wr_count && !restart && cnt_q == '0)
      |=> (cnt_q == $past(reload_q)));
endmodule

// File: rtl/dmt_timer.sv
module dmt_timer #(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick_src,
   input  logic             ovf_irq_en,
   input  logic             ext_tick,
   input  logic             wr_count,
   input  logic             wr_reload,
   input  logic             wr_match0,
   input  logic             wr_match1,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_level,
   output logic             event_pulse
);
   import dmt_pkg::*;

   if (CNT_W < 2) begin : g_bad_width
      $error("dmt_timer: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0]                reload_q;
   logic [NUM_MATCH-1:0][CNT_W-1:0] match_q;
   logic [NUM_MATCH-1:0]            wr_match;
   logic [CNT_W-1:0]                cnt_q;
   logic                            run_q;
   logic                            dec;
   logic                            tick;
   logic                            step_evt;
   logic                            evt_q;
   logic                            irq_q;

   assign wr_match = {wr_match1, wr_match0};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
      end else if (wr_reload) begin
         reload_q <= wr_data;
      end
   end

   for (genvar i = 0; i < NUM_MATCH; i++) begin : g_mreg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            match_q[i] <= '0;
         end else if (wr_match[i]) begin
            match_q[i] <= wr_data;
         end
      end
   end

   dmt_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) i_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_sel  (tick_src),
      .ext_tick (ext_tick),
      .tick_o   (tick)
   );

   dmt_count_core #(.CNT_W(CNT_W)) i_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .tick      (tick),
      .wr_count  (wr_count),
      .wr_reload (wr_reload),
      .wr_data   (wr_data),
      .reload_q  (reload_q),
      .cnt_q     (cnt_q),
      .run_q     (run_q),
      .dec_o     (dec)
   );

   dmt_match_unit #(.CNT_W(CNT_W)) i_match (
      .reload_i   (reload_q),
      .match_i    (match_q),
      .cnt_i      (cnt_q),
      .ovf_en_i   (ovf_irq_en),
      .step_evt_o (step_evt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         evt_q <= dec & step_evt;
         irq_q <= irq_q ^ (dec & step_evt);
      end
   end

   assign count_o     = run_q ? cnt_q : reload_q;
   assign irq_level   = irq_q;
   assign event_pulse = evt_q;

   // R9
   irq_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |-> (irq_q != $past(irq_q)));
   // R9
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_q |-> (irq_q == $past(irq_q)));
endmodule

// File: tb/test_dmt_timer.sv
module test_dmt_timer;
   localparam int unsigned W = 32;

   typedef struct {
      logic [W-1:0] cnt;
      logic         irq;
      logic         evt;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0, tick_src = 1'b0, ovf_irq_en = 1'b0, ext_tick = 1'b0;
   logic         wr_count = 1'b0, wr_reload = 1'b0, wr_match0 = 1'b0, wr_match1 = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] count_o;
   logic         irq_level, event_pulse;

   int checks = 0;
   int fails  = 0;
   exp_t q[$];

   logic         m_run = 1'b0;
   logic [W-1:0] m_cnt = '0, m_rel = '0, m_m0 = '0, m_m1 = '0;
   logic         m_irq = 1'b0;

   always #5 clk = ~clk;

   dmt_timer #(.CNT_W(W), .SYNC_STAGES(2)) i_dmt_timer (
      .clk(clk), .rst_n(rst_n), .en(en), .tick_src(tick_src), .ovf_irq_en(ovf_irq_en),
      .ext_tick(ext_tick), .wr_count(wr_count), .wr_reload(wr_reload),
      .wr_match0(wr_match0), .wr_match1(wr_match1), .wr_data(wr_data),
      .count_o(count_o), .irq_level(irq_level), .event_pulse(event_pulse)
   );

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic check_now(input logic [W-1:0] ec, input logic ei, input logic ee,
                            input string tag);
      checks++;
      if (count_o !== ec || irq_level !== ei || event_pulse !== ee) begin
         fails++;
         $display("FAIL %s: count=%0d irq=%0b evt=%0b expected count=%0d irq=%0b evt=%0b",
                  tag, count_o, irq_level, event_pulse, ec, ei, ee);
      end
   endtask

   // monitor: compares each queued expectation just after the edge it belongs to
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check_now(e.cnt, e.irq, e.evt, e.tag);
         end
      end
   end

   function automatic logic [W-1:0] eff(input logic [W-1:0] m, input logic [W-1:0] r);
      return (m < r) ? m : '0;
   endfunction

   // driver: one clock with every-clock ticking; expected outputs from the requirements
   task automatic step(input logic e, input logic o, input logic wc, input logic wrl,
                       input logic w0, input logic w1, input logic [W-1:0] d, input string tag);
      exp_t x;
      logic evt;
      logic [W-1:0] n, e0, e1;
      en = e; ovf_irq_en = o; wr_count = wc; wr_reload = wrl;
      wr_match0 = w0; wr_match1 = w1; wr_data = d;
      evt = 1'b0;
      e0 = eff(m_m0, m_rel);
      e1 = eff(m_m1, m_rel);
      if (!e) begin
         m_run = 1'b0;
      end else if (!m_run) begin
         m_run = 1'b1; m_cnt = m_rel;                       // R3
      end else if (wc) begin
         m_cnt = d;                                          // R10
      end else if (wrl && m_rel == '0 && d != '0) begin
         m_cnt = d;                                          // R11
      end else if (m_cnt == '0) begin
         m_cnt = m_rel;                                      // R4
      end else begin
         n = m_cnt - 1;
         if (n == '0) evt = o || e0 == '0 || e1 == '0;       // R8
         else         evt = (n == e0) || (n == e1);          // R6, R7
         m_cnt = n;
      end
      if (wrl) m_rel = d;
      if (w0)  m_m0 = d;
      if (w1)  m_m1 = d;
      if (evt) m_irq = ~m_irq;                               // R9
      x.cnt = m_run ? m_cnt : m_rel;                         // R2
      x.irq = m_irq; x.evt = evt; x.tag = tag;
      q.push_back(x);
      @(negedge clk);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(en, ovf_irq_en, 0, 0, 0, 0, '0, tag);
   endtask

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      check_now('0, 1'b0, 1'b0, "R1 during reset");
      rst_n = 1'b1;
      step(0, 0, 0, 0, 0, 0, '0, "R1 after reset");
      step(0, 0, 0, 1, 0, 0, 32'd10, "R2 reload shown while disabled");
      step(0, 0, 0, 0, 1, 0, 32'd7, "R6 match0 write");
      step(0, 0, 0, 0, 0, 1, 32'd3, "R6 match1 write");
      step(0, 0, 1, 0, 0, 0, 32'd4, "R10 count write ignored while disabled");
      step(1, 0, 0, 0, 0, 0, '0, "R3 enable loads reload");
      idle(24, "R7 match events, R4 decrement and wrap");
      step(1, 1, 0, 0, 0, 0, '0, "R8 overflow enable");
      idle(12, "R8 zero event with overflow enabled");
      step(1, 0, 1, 0, 0, 0, 32'd5, "R10 count write while running");
      idle(3, "R10 count after write");
      step(1, 0, 0, 0, 0, 1, 32'd20, "R6 match at or above reload");
      idle(14, "R6 large match counts as zero, R8 zero event");
      step(1, 0, 0, 0, 1, 0, 32'd10, "R6 match equal to reload");
      idle(12, "R6 R8 equal match treated as zero");
      step(0, 0, 0, 0, 0, 0, '0, "R2 disable shows reload");
      step(0, 0, 0, 1, 0, 0, 32'd0, "R2 reload cleared");
      step(1, 0, 0, 0, 0, 0, '0, "R3 enable with zero reload");
      idle(3, "R4 zero reload holds at zero");
      step(1, 0, 0, 1, 0, 0, 32'd6, "R11 restart on nonzero reload");
      idle(8, "R11 counting after restart");
      step(1, 0, 0, 0, 0, 0, '0, "R9 final");
      @(negedge clk);
      // external tick mode: count drops once per rising edge of ext_tick
      en = 1'b0; tick_src = 1'b1; wr_reload = 1'b1; wr_data = 32'd10;
      @(negedge clk);
      wr_reload = 1'b0; en = 1'b1;
      @(negedge clk);
      check_now(32'd10, m_irq, 1'b0, "R5 external mode start");
      repeat (6) @(negedge clk);
      check_now(32'd10, m_irq, 1'b0, "R5 no tick while ext_tick low");
      ext_tick = 1'b1;
      repeat (6) @(negedge clk);
      check_now(32'd9, m_irq, 1'b0, "R5 one step per rising edge");
      repeat (6) @(negedge clk);
      check_now(32'd9, m_irq, 1'b0, "R5 steady high level has no effect");
      ext_tick = 1'b0;
      repeat (6) @(negedge clk);
      ext_tick = 1'b1;
      repeat (6) @(negedge clk);
      check_now(32'd8, m_irq, 1'b0, "R5 second rising edge");
      report();
   end
endmodule